// File: doc/BRIEF.md
# SDRAM Command Timing Checker

A passive monitor that sits on the command lines of a single-data-rate SDRAM interface and judges each command against the state of the four internal banks and the clock counts since earlier commands. It never drives the bus. Each rising clock edge it decodes the command from the chip-select, row-strobe, column-strobe and write-enable lines (qualified by clock enable). It updates which banks are open and restarts the interval counters that the command affects.

When a command arrives too early for a minimum spacing rule, or is illegal for the bank state, the monitor raises a sticky error flag and latches a code naming the first rule broken. The flag and code stay put until the clear input is pulsed. Every minimum spacing is a parameter in clocks, and the defaults match a 100 MHz part. Typical uses are as a protocol checker inside a controller testbench, or as a debug probe left in silicon behind the memory controller.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A cycle with `cke_i` low or `cs_ni` high is no command. It changes no bank state and raises no error. With `cke_i` high and `cs_ni` low, {ras_ni,cas_ni,we_ni} decode as follows: 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 no command.
- R2: Each of the four banks, chosen by `ba_i`, is open or closed. A read or write to a closed bank gives code 9. An activate to an open bank gives code 10.
- R3: An activate issued fewer than T_RRD (2) clocks after an activate to a different bank gives code 1.
- R4: A read or write issued fewer than T_RCD (2) clocks after its bank's activate gives code 2.
- R5: A precharge of an open bank issued fewer than T_RAS (5) clocks after its activate gives code 3. Otherwise, a precharge issued fewer than T_DPL clocks after that bank's last write gives code 4.
- R6: An activate issued fewer than T_RC (7) clocks after the same bank's previous activate gives code 5. Otherwise, an activate issued fewer than T_RP (2) clocks after that bank's precharge gives code 6.
- R7: Any command issued fewer than T_MRD (2) clocks after a mode set gives code 7. Any command issued fewer than T_RRC (7) clocks after a refresh gives code 8.
- R8: A refresh or mode set issued while any bank is open gives code 11.
- R9: A precharge with `a10_i` high closes every bank. With `a10_i` low it closes only the bank on `ba_i`.
- R10: After reset `err_o` is 0 and `code_o` is 0. A violation sets `err_o` and `code_o` on the clock edge that samples the command. Later violations leave the code unchanged. `clr_i` clears both, and a violation in the same cycle as `clr_i` is latched.
- R11: When one command breaks several rules, the code follows this order: mode-set or refresh spacing, then the bank rule (state before timing), then T_RRD. A precharge-all reports the lowest-numbered offending bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Memory interface clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable seen by the memory |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | BA_W | Bank select |
| a10_i | input | 1 | Precharge-all qualifier |
| clr_i | input | 1 | Clears the latched error |
| err_o | output | 1 | Sticky violation flag |
| code_o | output | 4 | Code of the first violation since clear |

## Verification
Each spacing rule is driven at exactly one clock short of its minimum, which must flag, and at exactly the minimum, which must stay silent. This separates an off-by-one counter from a correct one. State rules are exercised through legal open/read/close flows followed by access to a closed bank. Deselected and clock-disabled commands are followed by an access that would expose a wrongly opened bank. Precharge-all is contrasted with a single-bank precharge. Commands that break two rules at once, and violations that coincide with a clear, show the priority order and the first-error latching.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS, CMD_BST
  } cmd_e;

  typedef enum logic [3:0] {
    V_NONE   = 4'd0,
    V_RRD    = 4'd1,
    V_RCD    = 4'd2,
    V_RAS    = 4'd3,
    V_DPL    = 4'd4,
    V_RC     = 4'd5,
    V_RP     = 4'd6,
    V_MRD    = 4'd7,
    V_RRC    = 4'd8,
    V_CLOSED = 4'd9,
    V_REOPEN = 4'd10,
    V_BUSY   = 4'd11
  } viol_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_mon_decode.sv
module sdram_mon_decode
  import sdram_mon_pkg::*;
(
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);

  always_comb begin
    cmd_o = CMD_NOP;
    if (cke_i && !cs_ni) begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b000:  cmd_o = CMD_MRS;
        3'b001:  cmd_o = CMD_REF;
        3'b010:  cmd_o = CMD_PRE;
        3'b011:  cmd_o = CMD_ACT;
        3'b100:  cmd_o = CMD_WR;
        3'b101:  cmd_o = CMD_RD;
        3'b110:  cmd_o = CMD_BST;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_mon_bank.sv
module sdram_mon_bank
  import sdram_mon_pkg::*;
#(
  parameter int T_RCD = 2,
  parameter int T_RAS = 5,
  parameter int T_RC  = 7,
  parameter int T_RP  = 2,
  parameter int T_DPL = 1,
  parameter int CW    = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  cmd_e  cmd_i,
  input  logic  sel_i,
  input  logic  all_i,
  output logic  open_o,
  output viol_e code_o
);

  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic          open_q, open_d;
  logic [CW-1:0] act_q, act_d, pre_q, pre_d, wr_q, wr_d;
  logic          pre_hit;

  assign pre_hit = (cmd_i == CMD_PRE) && (sel_i || all_i) && open_q;
  assign open_o  = open_q;

  always_comb begin
    code_o = V_NONE;
    if (sel_i && cmd_i == CMD_ACT) begin
      if (open_q)                           code_o = V_REOPEN;
      else if (act_q < CW'(T_RC))           code_o = V_RC;
      else if (pre_q < CW'(T_RP))           code_o = V_RP;
    end else if (sel_i && (cmd_i == CMD_RD || cmd_i == CMD_WR)) begin
      if (!open_q)                          code_o = V_CLOSED;
      else if (act_q < CW'(T_RCD))          code_o = V_RCD;
    end else if (pre_hit) begin
      if (act_q < CW'(T_RAS))               code_o = V_RAS;
      else if (wr_q < CW'(T_DPL))           code_o = V_DPL;
    end
  end

  always_comb begin
    open_d = open_q;
    act_d  = (act_q == CMAX) ? act_q : act_q + 1'b1;
    pre_d  = (pre_q == CMAX) ? pre_q : pre_q + 1'b1;
    wr_d   = (wr_q  == CMAX) ? wr_q  : wr_q  + 1'b1;
    if (sel_i && cmd_i == CMD_ACT) begin
      open_d = 1'b1;
      act_d  = CW'(1);
    end
    if (sel_i && cmd_i == CMD_WR && open_q) wr_d = CW'(1);
    if (pre_hit) begin
      open_d = 1'b0;
      pre_d  = CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      act_q  <= CMAX;
      pre_q  <= CMAX;
      wr_q   <= CMAX;
    end else begin
      open_q <= open_d;
      act_q  <= act_d;
      pre_q  <= pre_d;
      wr_q   <= wr_d;
    end
  end

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int T_RRD = 2,
  parameter int T_RCD = 2,
  parameter int T_RAS = 5,
  parameter int T_RC  = 7,
  parameter int T_RP  = 2,
  parameter int T_DPL = 1,
  parameter int T_MRD = 2,
  parameter int T_RRC = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cke_i,
  input  logic            cs_ni,
  input  logic            ras_ni,
  input  logic            cas_ni,
  input  logic            we_ni,
  input  logic [BA_W-1:0] ba_i,
  input  logic            a10_i,
  input  logic            clr_i,
  output logic            err_o,
  output logic [3:0]      code_o
);

  localparam int NBANK = 2 ** BA_W;
  localparam int TMAX  = max2(max2(max2(T_RRD, T_RCD), max2(T_RAS, T_RC)),
                              max2(max2(T_RP, T_DPL), max2(T_MRD, T_RRC)));
  localparam int CW    = $clog2(TMAX + 1);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  cmd_e       cmd;
  logic       pre_all;
  logic       any_open;
  logic [NBANK-1:0] bank_open;
  viol_e      bank_code [NBANK];
  viol_e      bank_pick, viol;

  logic [CW-1:0]   rrd_q, rrd_d, mrd_q, mrd_d, rrc_q, rrc_d;
  logic [BA_W-1:0] last_ba_q, last_ba_d;
  logic            err_q, err_d;
  logic [3:0]      code_q, code_d;

  sdram_mon_decode u_dec (
    .cke_i (cke_i), .cs_ni (cs_ni), .ras_ni (ras_ni),
    .cas_ni(cas_ni), .we_ni (we_ni), .cmd_o (cmd)
  );

  assign pre_all = (cmd == CMD_PRE) && a10_i;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    sdram_mon_bank #(
      .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC),
      .T_RP (T_RP),  .T_DPL(T_DPL), .CW  (CW)
    ) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cmd_i  (cmd),
      .sel_i  (ba_i == BA_W'(b)),
      .all_i  (pre_all),
      .open_o (bank_open[b]),
      .code_o (bank_code[b])
    );
  end

  assign any_open = |bank_open;

  // lowest-numbered bank reporting a problem wins
  always_comb begin
    bank_pick = V_NONE;
    for (int b = NBANK - 1; b >= 0; b--) begin
      if (bank_code[b] != V_NONE) bank_pick = bank_code[b];
    end
  end

  always_comb begin
    viol = V_NONE;
    if (cmd != CMD_NOP) begin
      if (mrd_q < CW'(T_MRD))                 viol = V_MRD;
      else if (rrc_q < CW'(T_RRC))            viol = V_RRC;
      else if (bank_pick != V_NONE)           viol = bank_pick;
      else if ((cmd == CMD_REF || cmd == CMD_MRS) && any_open)
                                              viol = V_BUSY;
      else if (cmd == CMD_ACT && ba_i != last_ba_q && rrd_q < CW'(T_RRD))
                                              viol = V_RRD;
    end
  end

  always_comb begin
    rrd_d     = (rrd_q == CMAX) ? rrd_q : rrd_q + 1'b1;
    mrd_d     = (mrd_q == CMAX) ? mrd_q : mrd_q + 1'b1;
    rrc_d     = (rrc_q == CMAX) ? rrc_q : rrc_q + 1'b1;
    last_ba_d = last_ba_q;
    if (cmd == CMD_ACT) begin
      rrd_d     = CW'(1);
      last_ba_d = ba_i;
    end
    if (cmd == CMD_MRS) mrd_d = CW'(1);
    if (cmd == CMD_REF) rrc_d = CW'(1);

    err_d  = clr_i ? 1'b0 : err_q;
    code_d = clr_i ? 4'd0 : code_q;
    if (viol != V_NONE && !err_d) begin
      err_d  = 1'b1;
      code_d = viol;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rrd_q     <= CMAX;
      mrd_q     <= CMAX;
      rrc_q     <= CMAX;
      last_ba_q <= '0;
      err_q     <= 1'b0;
      code_q    <= 4'd0;
    end else begin
      rrd_q     <= rrd_d;
      mrd_q     <= mrd_d;
      rrc_q     <= rrc_d;
      last_ba_q <= last_ba_d;
      err_q     <= err_d;
      code_q    <= code_d;
    end
  end

  assign err_o  = err_q;
  assign code_o = code_q;

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
  parameter int BA_W  = 2,
  parameter int T_RCD = 2,
  parameter int T_MRD = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cke_i,
  input logic            cs_ni,
  input logic            ras_ni,
  input logic            cas_ni,
  input logic            we_ni,
  input logic [BA_W-1:0] ba_i,
  input logic            a10_i,
  input logic            clr_i,
  input logic            err_o,
  input logic [3:0]      code_o
);

  logic live, is_mrs, is_act, is_rdwr;
  assign live    = cke_i && !cs_ni && !(ras_ni && cas_ni && we_ni);
  assign is_mrs  = live && !ras_ni && !cas_ni && !we_ni;
  assign is_act  = live && !ras_ni && cas_ni && we_ni;
  assign is_rdwr = live && ras_ni && !cas_ni;

  // R10: latched code holds until cleared
  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> (err_o && $stable(code_o)));

  // R1: deselected or clock-disabled cycle raises nothing
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_o && !clr_i && (cs_ni || !cke_i)) |=> !err_o);

  // R7: command right after mode set is flagged
  p_mode_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((T_MRD > 1) && live && $past(is_mrs)) |=> err_o);

  // R4: column access right after activate of same bank is flagged
  p_col_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((T_RCD > 1) && is_rdwr && $past(is_act) && ba_i == $past(ba_i)) |=> err_o);

  // R10: the flag only rises after a real command
  p_rise_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(live));

  // R10: flag and code agree
  p_code_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (code_o != 4'd0));

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(
  .BA_W(BA_W), .T_RCD(T_RCD), .T_MRD(T_MRD)
) u_chk (.*);

// File: tb/sdram_cmd_monitor_test.sv
module sdram_cmd_monitor_test;

  localparam logic [2:0] K_MRS = 3'b000, K_REF = 3'b001, K_PRE = 3'b010,
                         K_ACT = 3'b011, K_WR  = 3'b100, K_RD  = 3'b101;

  logic clk_i = 1'b0, rst_ni;
  logic cke_i, cs_ni, ras_ni, cas_ni, we_ni, a10_i, clr_i;
  logic [1:0] ba_i;
  logic err_o;
  logic [3:0] code_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  sdram_cmd_monitor #(.T_DPL(2)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cke_i(cke_i), .cs_ni(cs_ni),
    .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni), .ba_i(ba_i),
    .a10_i(a10_i), .clr_i(clr_i), .err_o(err_o), .code_o(code_o)
  );

  task automatic idle();
    cke_i = 1; cs_ni = 0; {ras_ni, cas_ni, we_ni} = 3'b111;
    ba_i = 0; a10_i = 0; clr_i = 0;
  endtask

  task automatic raw(input logic cke, input logic cs, input logic [2:0] k,
                     input logic [1:0] ba, input logic a10, input logic clr);
    cke_i = cke; cs_ni = cs; {ras_ni, cas_ni, we_ni} = k;
    ba_i = ba; a10_i = a10; clr_i = clr;
    @(negedge clk_i);
    idle();
  endtask

  task automatic issue(input logic [2:0] k, input logic [1:0] ba, input logic a10 = 0);
    raw(1, 0, k, ba, a10, 0);
  endtask

  task automatic nop(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic e, input logic [3:0] c);
    checks++;
    if (err_o !== e || code_o !== c) begin
      errors++;
      $display("FAIL %s: err=%0b code=%0d expected err=%0b code=%0d",
               req, err_o, code_o, e, c);
    end
  endtask

  task automatic do_reset();
    idle();
    rst_ni = 0;
    nop(3);
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 reset", 0, 0);
  endtask

  task automatic t_ignored();
    do_reset();
    raw(1, 1, K_ACT, 0, 0, 0);        // deselected activate
    raw(0, 0, K_ACT, 1, 0, 0);        // clock-disabled activate
    raw(0, 0, K_MRS, 0, 0, 0);
    chk("R1 ignored commands", 0, 0);
    nop(8);
    issue(K_RD, 1);
    chk("R1 bank stayed closed", 1, 9);
  endtask

  task automatic t_state();
    do_reset();
    issue(K_ACT, 0); nop(1); issue(K_RD, 0); nop(4); issue(K_PRE, 0);
    chk("R2 legal flow", 0, 0);
    nop(2);
    issue(K_WR, 0);
    chk("R2 write closed bank", 1, 9);
    do_reset();
    issue(K_ACT, 1); nop(8); issue(K_ACT, 1);
    chk("R2 activate open bank", 1, 10);
  endtask

  task automatic t_rrd();
    do_reset();
    issue(K_ACT, 0); issue(K_ACT, 1);
    chk("R3 rrd short", 1, 1);
    do_reset();
    issue(K_ACT, 0); nop(1); issue(K_ACT, 1);
    chk("R3 rrd exact", 0, 0);
  endtask

  task automatic t_rcd();
    do_reset();
    issue(K_ACT, 2); issue(K_RD, 2);
    chk("R4 rcd short", 1, 2);
    do_reset();
    issue(K_ACT, 2); nop(1); issue(K_WR, 2);
    chk("R4 rcd exact", 0, 0);
  endtask

  task automatic t_ras_dpl();
    do_reset();
    issue(K_ACT, 0); nop(3); issue(K_PRE, 0);
    chk("R5 ras short", 1, 3);
    do_reset();
    issue(K_ACT, 0); nop(4); issue(K_PRE, 0);
    chk("R5 ras exact", 0, 0);
    do_reset();
    issue(K_ACT, 0); nop(9); issue(K_WR, 0); issue(K_PRE, 0);
    chk("R5 dpl short", 1, 4);
    do_reset();
    issue(K_ACT, 0); nop(9); issue(K_WR, 0); nop(1); issue(K_PRE, 0);
    chk("R5 dpl exact", 0, 0);
  endtask

  task automatic t_rc_rp();
    do_reset();
    issue(K_ACT, 0); nop(4); issue(K_PRE, 0);
    chk("R6 precharge legal", 0, 0);
    issue(K_ACT, 0);
    chk("R6 rc short", 1, 5);
    do_reset();
    issue(K_ACT, 0); nop(9); issue(K_PRE, 0); issue(K_ACT, 0);
    chk("R6 rp short", 1, 6);
    do_reset();
    issue(K_ACT, 0); nop(9); issue(K_PRE, 0); nop(1); issue(K_ACT, 0);
    chk("R6 rp exact", 0, 0);
  endtask

  task automatic t_mrd_rrc();
    do_reset();
    issue(K_MRS, 0); issue(K_ACT, 0);
    chk("R7 mrd short", 1, 7);
    do_reset();
    issue(K_MRS, 0); nop(1); issue(K_ACT, 0);
    chk("R7 mrd exact", 0, 0);
    do_reset();
    issue(K_REF, 0); nop(5); issue(K_ACT, 3);
    chk("R7 rrc short", 1, 8);
    do_reset();
    issue(K_REF, 0); nop(6); issue(K_ACT, 3);
    chk("R7 rrc exact", 0, 0);
  endtask

  task automatic t_busy();
    do_reset();
    issue(K_ACT, 3); nop(8); issue(K_REF, 0);
    chk("R8 refresh with open bank", 1, 11);
    do_reset();
    issue(K_ACT, 2); nop(8); issue(K_MRS, 0);
    chk("R8 mode set with open bank", 1, 11);
  endtask

  task automatic t_pre_all();
    do_reset();
    issue(K_ACT, 0); nop(1); issue(K_ACT, 1); nop(6); issue(K_PRE, 0, 1);
    nop(2); issue(K_RD, 1);
    chk("R9 precharge-all closes bank 1", 1, 9);
    do_reset();
    issue(K_ACT, 0); nop(1); issue(K_ACT, 1); nop(6); issue(K_PRE, 0, 0);
    nop(2); issue(K_RD, 1);
    chk("R9 single precharge keeps bank 1", 0, 0);
    issue(K_RD, 0);
    chk("R9 single precharge closed bank 0", 1, 9);
  endtask

  task automatic t_sticky();
    do_reset();
    issue(K_ACT, 0); issue(K_ACT, 1);
    nop(1); issue(K_RD, 2);
    chk("R10 first code kept", 1, 1);
    raw(1, 0, 3'b111, 0, 0, 1);
    chk("R10 clear", 0, 0);
    issue(K_RD, 2); nop(1);
    raw(1, 0, K_WR, 3, 0, 1);
    chk("R10 violation with clear latched", 1, 9);
  endtask

  task automatic t_priority();
    do_reset();
    issue(K_MRS, 0); issue(K_RD, 3);
    chk("R11 mode spacing before state", 1, 7);
    do_reset();
    issue(K_ACT, 0); issue(K_ACT, 0);
    chk("R11 state before timing", 1, 10);
    do_reset();
    issue(K_ACT, 1); nop(1); issue(K_ACT, 2); nop(2); issue(K_PRE, 0, 1);
    chk("R11 precharge-all lowest bank", 1, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ignored();
    t_state();
    t_rrd();
    t_rcd();
    t_ras_dpl();
    t_rc_rp();
    t_mrd_rrc();
    t_busy();
    t_pre_all();
    t_sticky();
    t_priority();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule